// File: doc/BRIEF.md
# Single-Transaction Coherence Controller

This block is the central agent that keeps one tracked cache line coherent across a set of caches. Each cache presents requests on its own port. A request asks for the line's data, for permission to store into it, or for both. The controller serves exactly one such transaction at a time. Every other requester keeps its request raised until the controller accepts it. Allowing only one open transaction removes the deadlock in which a cache waits on the controller while its own snooper is locked and cannot answer.

For an accepted request, the controller sends a snoop to every cache except the requester and waits for each of them to acknowledge. A snoop either invalidates the line or downgrades it to shared. If an acknowledging cache held the line Modified, its copy is written into the controller's line store. The controller then answers the requester. The answer grants Modified for any request that asks to store. A data-only request gets Shared if another cache still holds a copy, and Exclusive if none does. Caches arbitrate round-robin for the single transaction slot. A busy output shows the caches when a transaction is open.

Top module: `coh_txn_ctrl`

## Requirements
- R1: A request is accepted (one-cycle `req_accept` bit for that cache) only in a cycle where `busy` is low, at most one cache is accepted per cycle, and a cache whose `req_valid` is low is never accepted. Request kind encoding: bit 0 = wants data, bit 1 = wants store permission; 00 is not used.
- R2: Among the caches raising `req_valid` in an idle cycle, the winner is the first one found scanning upward (wrapping) from the cache after the last winner. After reset the scan starts at cache 0.
- R3: `busy` rises in the cycle after an acceptance and stays high up to and including the response cycle. It is low in all other cycles, so only one transaction is ever open.
- R4: In the cycle after an acceptance, `snoop_valid` pulses for exactly one cycle to every cache except the requester. `snoop_inv` is 1 (invalidate) when the request's store bit is set and 0 (downgrade to shared) otherwise.
- R5: The response is issued one cycle after the cycle in which the last outstanding snoop acknowledgement arrives, never earlier. It is a one-cycle pulse on `resp_valid` for the requester only.
- R6: An acknowledgement with `ack_mod` set writes that cache's `ack_data` into the line store before the response is formed.
- R7: `resp_state` during a response is 3 (Modified) when the store bit was set. Otherwise it is 1 (Shared) if any snooped cache acknowledged with `ack_keep` set, and 2 (Exclusive) if none did. It is 0 outside responses.
- R8: `resp_data` during a response equals the line store when the data bit was set, and is zero when it was not.
- R9: After reset `busy`, `req_accept`, `snoop_valid` and `resp_valid` are low, and the line store holds zero.
- R10: With caches that follow the grants, no two caches are ever Modified together, and while one cache is Modified or Exclusive no other cache holds the line in Shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_CACHE | Per-cache request raised until accepted |
| req_kind | input | 2*N_CACHE | Per-cache request kind, 2 bits each |
| req_accept | output | N_CACHE | One-cycle acceptance of a request |
| snoop_valid | output | N_CACHE | One-cycle snoop to each non-requesting cache |
| snoop_inv | output | 1 | Snoop type: 1 invalidate, 0 downgrade |
| ack_valid | input | N_CACHE | One-cycle snoop acknowledgement per cache |
| ack_mod | input | N_CACHE | Acknowledging cache held the line Modified |
| ack_keep | input | N_CACHE | Acknowledging cache still holds a copy |
| ack_data | input | N_CACHE*DATA_W | Per-cache write-back data |
| resp_valid | output | N_CACHE | One-cycle response to the requester |
| resp_state | output | 2 | Granted line state |
| resp_data | output | DATA_W | Line data returned to the requester |
| busy | output | 1 | A transaction is open |

## Verification
The assertions assume that every snooped cache acknowledges exactly once, in a later cycle than the snoop, and that no other cache acknowledges. They assume that `ack_mod` is set only by a cache that really held the line Modified, and that a request stays raised with a stable, nonzero kind until it is accepted. The bench keeps inside these limits by modelling each cache as a state-tracking agent. Each agent answers its own snoops after a delay of one to three cycles, takes its acknowledgement values from the line state it held when snooped, and lowers its request in the cycle after acceptance.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SNOOP   = 2'd1,
    ST_COLLECT = 2'd2,
    ST_RESPOND = 2'd3
  } ctl_state_e;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2,
    LN_MOD = 2'd3
  } line_state_e;

  localparam int KIND_W         = 2;
  localparam int KIND_DATA_BIT  = 0;
  localparam int KIND_STORE_BIT = 1;
endpackage

// File: rtl/ccm_rr_arbiter.sv
module ccm_rr_arbiter #(
  parameter int N_CACHE = 4,
  localparam int IDX_W = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CACHE-1:0] req,
  input  logic               take,
  output logic [N_CACHE-1:0] grant,
  output logic               any
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  // scan starts one past the previous winner and wraps
  always_comb begin
    grant = '0;
    any   = 1'b0;
    ptr_d = ptr_q;
    for (int k = 0; k < N_CACHE; k++) begin
      int idx;
      idx = int'(ptr_q) + 1 + k;
      if (idx >= N_CACHE) idx = idx - N_CACHE;
      if (!any && req[idx]) begin
        grant[idx] = 1'b1;
        any        = 1'b1;
        ptr_d      = IDX_W'(idx);
      end
    end
  end

  assign ptr_en = take && any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= IDX_W'(N_CACHE - 1);
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/ccm_snoop_collect.sv
module ccm_snoop_collect #(
  parameter int N_CACHE = 4,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      arm,
  input  logic [N_CACHE-1:0]        target,
  input  logic                      active,
  input  logic [N_CACHE-1:0]        ack_valid,
  input  logic [N_CACHE-1:0]        ack_mod,
  input  logic [N_CACHE-1:0]        ack_keep,
  input  logic [N_CACHE*DATA_W-1:0] ack_data,
  output logic                      done,
  output logic                      holder,
  output logic [DATA_W-1:0]         line
);
  logic [N_CACHE-1:0] pend_q;
  logic [N_CACHE-1:0] pend_d;
  logic               pend_en;
  logic               keep_q;
  logic               keep_d;
  logic               keep_en;
  logic [DATA_W-1:0]  line_q;
  logic [DATA_W-1:0]  wb_d;
  logic               wb_en;
  logic [N_CACHE-1:0] hit;

  assign hit = pend_q & ack_valid;

  always_comb begin
    pend_en = arm || active;
    pend_d  = arm ? target : (pend_q & ~ack_valid);
    keep_en = arm || active;
    keep_d  = arm ? 1'b0 : (keep_q || |(hit & ack_keep));
  end

  // write-back from the single Modified holder, if any
  always_comb begin
    wb_en = 1'b0;
    wb_d  = line_q;
    for (int i = 0; i < N_CACHE; i++) begin
      if (active && hit[i] && ack_mod[i]) begin
        wb_en = 1'b1;
        wb_d  = ack_data[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      keep_q <= 1'b0;
      line_q <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (keep_en) keep_q <= keep_d;
      if (wb_en)   line_q <= wb_d;
    end
  end

  assign done   = active && ((pend_q & ~ack_valid) == '0);
  assign holder = keep_q;
  assign line   = line_q;
endmodule

// File: rtl/coh_txn_ctrl.sv
module coh_txn_ctrl
  import ccm_pkg::*;
#(
  parameter int N_CACHE = 4,
  parameter int DATA_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_CACHE-1:0]         req_valid,
  input  logic [N_CACHE*KIND_W-1:0]  req_kind,
  output logic [N_CACHE-1:0]         req_accept,
  output logic [N_CACHE-1:0]         snoop_valid,
  output logic                       snoop_inv,
  input  logic [N_CACHE-1:0]         ack_valid,
  input  logic [N_CACHE-1:0]         ack_mod,
  input  logic [N_CACHE-1:0]         ack_keep,
  input  logic [N_CACHE*DATA_W-1:0]  ack_data,
  output logic [N_CACHE-1:0]         resp_valid,
  output logic [1:0]                 resp_state,
  output logic [DATA_W-1:0]          resp_data,
  output logic                       busy
);
  ctl_state_e         state_q;
  ctl_state_e         state_d;
  logic [N_CACHE-1:0] grant;
  logic               grant_any;
  logic               take;
  logic [N_CACHE-1:0] cur_oh_q;
  logic               store_q;
  logic               data_q;
  logic [KIND_W-1:0]  sel_kind;
  logic               txn_en;
  logic               col_done;
  logic               col_holder;
  logic [DATA_W-1:0]  line;
  logic               in_idle;
  logic               in_snoop;
  logic               in_collect;
  logic               in_respond;

  assign in_idle    = (state_q == ST_IDLE);
  assign in_snoop   = (state_q == ST_SNOOP);
  assign in_collect = (state_q == ST_COLLECT);
  assign in_respond = (state_q == ST_RESPOND);

  assign take = in_idle;

  ccm_rr_arbiter #(.N_CACHE(N_CACHE)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_valid),
    .take  (take),
    .grant (grant),
    .any   (grant_any)
  );

  ccm_snoop_collect #(.N_CACHE(N_CACHE), .DATA_W(DATA_W)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (in_snoop),
    .target    (~cur_oh_q),
    .active    (in_collect),
    .ack_valid (ack_valid),
    .ack_mod   (ack_mod),
    .ack_keep  (ack_keep),
    .ack_data  (ack_data),
    .done      (col_done),
    .holder    (col_holder),
    .line      (line)
  );

  always_comb begin
    sel_kind = '0;
    for (int i = 0; i < N_CACHE; i++) begin
      if (grant[i]) sel_kind = req_kind[i*KIND_W +: KIND_W];
    end
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (grant_any) state_d = ST_SNOOP;
      ST_SNOOP:   state_d = ST_COLLECT;
      ST_COLLECT: if (col_done) state_d = ST_RESPOND;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign txn_en = in_idle && grant_any;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cur_oh_q <= '0;
      store_q  <= 1'b0;
      data_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (txn_en) begin
        cur_oh_q <= grant;
        store_q  <= sel_kind[KIND_STORE_BIT];
        data_q   <= sel_kind[KIND_DATA_BIT];
      end
    end
  end

  // outputs
  assign req_accept  = in_idle ? grant : '0;
  assign busy        = !in_idle;
  assign snoop_valid = in_snoop ? ~cur_oh_q : '0;
  assign snoop_inv   = in_snoop && store_q;
  assign resp_valid  = in_respond ? cur_oh_q : '0;
  assign resp_data   = (in_respond && data_q) ? line : '0;

  always_comb begin
    if (!in_respond)     resp_state = LN_INV;
    else if (store_q)    resp_state = LN_MOD;
    else if (col_holder) resp_state = LN_SHR;
    else                 resp_state = LN_EXC;
  end
endmodule

// File: rtl/coh_txn_ctrl_chk.sv
module coh_txn_ctrl_chk #(
  parameter int N_CACHE = 4,
  parameter int DATA_W  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_CACHE-1:0]   req_valid,
  input logic [N_CACHE*2-1:0] req_kind,
  input logic [N_CACHE-1:0]   req_accept,
  input logic [N_CACHE-1:0]   snoop_valid,
  input logic                 snoop_inv,
  input logic [N_CACHE-1:0]   ack_valid,
  input logic [N_CACHE-1:0]   resp_valid,
  input logic [1:0]           resp_state,
  input logic                 busy
);
  logic [N_CACHE-1:0] store_bits;
  logic [N_CACHE-1:0] pend_chk;
  logic               inv_seen;

  for (genvar g = 0; g < N_CACHE; g++) begin : g_sb
    assign store_bits[g] = req_kind[2*g+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_chk <= '0;
      inv_seen <= 1'b0;
    end else if (|snoop_valid) begin
      pend_chk <= snoop_valid;
      inv_seen <= snoop_inv;
    end else begin
      pend_chk <= pend_chk & ~ack_valid;
    end
  end

  a_r1_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_accept) |-> (!busy && $onehot0(req_accept) && ((req_accept & ~req_valid) == '0)));

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_accept) |=> busy);

  a_r4_snoop_others: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_accept) |=> (snoop_valid == ~$past(req_accept)
                       && snoop_inv == $past(|(req_accept & store_bits))));

  a_r5_resp_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (|resp_valid) |-> (pend_chk == '0 && busy && $onehot0(resp_valid)));

  a_r7_mod_needs_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (|resp_valid) |-> ((resp_state == 2'd3) == inv_seen));

  a_r3_idle_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (|resp_valid) |=> !busy);
endmodule

bind coh_txn_ctrl coh_txn_ctrl_chk #(.N_CACHE(N_CACHE), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_kind    (req_kind),
  .req_accept  (req_accept),
  .snoop_valid (snoop_valid),
  .snoop_inv   (snoop_inv),
  .ack_valid   (ack_valid),
  .resp_valid  (resp_valid),
  .resp_state  (resp_state),
  .busy        (busy)
);

// File: tb/coh_txn_ctrl_bench.sv
module coh_txn_ctrl_bench;
  localparam int N = 4;
  localparam int W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N-1:0]     req_valid;
  logic [2*N-1:0]   req_kind;
  logic [N-1:0]     req_accept;
  logic [N-1:0]     snoop_valid;
  logic             snoop_inv;
  logic [N-1:0]     ack_valid;
  logic [N-1:0]     ack_mod;
  logic [N-1:0]     ack_keep;
  logic [N*W-1:0]   ack_data;
  logic [N-1:0]     resp_valid;
  logic [1:0]       resp_state;
  logic [W-1:0]     resp_data;
  logic             busy;

  always #10 clk = ~clk;

  coh_txn_ctrl #(.N_CACHE(N), .DATA_W(W)) u_coh_txn_ctrl (.*);

  int total = 0;
  int bad   = 0;

  // reference model of the controller
  int           m_ph;
  int           m_cur;
  int           m_kind;
  int           m_left;
  int           m_ptr;
  bit           m_keep;
  logic [W-1:0] m_mem;

  // cache agents
  int           cs[N];
  logic [W-1:0] cd[N];
  bit           waiting[N];
  bit           taken[N];
  int           rkind[N];
  int           ackcnt[N];
  bit           a_m[N];
  bit           a_k[N];
  logic [W-1:0] a_d[N];
  int unsigned  lcg = 32'h1234_5678;
  int           store_val = 1;
  int           busy_run = 0;
  int           resp_seen = 0;
  int           wb_resp = 0;

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return (lcg >> 16) & 32'h7fff;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rr_winner(input logic [N-1:0] rv);
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (m_ptr + 1 + k) % N;
      if (rv[idx]) return idx;
    end
    return -1;
  endfunction

  initial begin
    rst_n = 1'b0;
    req_valid = '0; req_kind = '0;
    ack_valid = '0; ack_mod = '0; ack_keep = '0; ack_data = '0;
    for (int i = 0; i < N; i++) begin
      cs[i] = 0; cd[i] = '0; waiting[i] = 0; taken[i] = 0;
      rkind[i] = 0; ackcnt[i] = 0; a_m[i] = 0; a_k[i] = 0; a_d[i] = '0;
    end
    m_ph = 0; m_cur = 0; m_kind = 0; m_left = 0; m_ptr = N - 1; m_keep = 0; m_mem = '0;

    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(resp_valid == '0, "R9 resp_valid after reset", resp_valid, 0);
    chk(snoop_valid == '0, "R9 snoop_valid after reset", snoop_valid, 0);
    chk(req_accept == '0, "R9 req_accept after reset", req_accept, 0);
    rst_n = 1'b1;

    // first cycle: every cache requests data at once (R2 start at cache 0)
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int win;
      logic [N-1:0] e_snoop;
      @(negedge clk);
      // drive acknowledgements
      ack_valid = '0; ack_mod = '0; ack_keep = '0;
      for (int i = 0; i < N; i++) begin
        if (ackcnt[i] > 0) begin
          ackcnt[i]--;
          if (ackcnt[i] == 0) begin
            ack_valid[i] = 1'b1;
            ack_mod[i]   = a_m[i];
            ack_keep[i]  = a_k[i];
            ack_data[i*W +: W] = a_d[i];
          end
        end
      end
      // cache activity and requests
      for (int i = 0; i < N; i++) begin
        if (!waiting[i] && ackcnt[i] == 0 && (cyc == 0 || rnd() % 4 == 0)) begin
          if (cs[i] == 2) begin
            cs[i] = 3;
          end else if (cs[i] == 3) begin
            cd[i] = W'(store_val); store_val++;
          end else if (cs[i] == 1) begin
            waiting[i] = 1; rkind[i] = 2;
          end else begin
            waiting[i] = 1; rkind[i] = (cyc == 0 || rnd() % 2 == 0) ? 1 : 3;
          end
        end
        req_valid[i] = waiting[i] && !taken[i];
        req_kind[2*i +: 2] = 2'(rkind[i]);
      end
      #1;
      // compare with reference model
      win = (m_ph == 0) ? rr_winner(req_valid) : -1;
      chk(req_accept == ((win >= 0) ? (N'(1) << win) : '0), "R1/R2 req_accept", req_accept,
          (win >= 0) ? (1 << win) : 0);
      chk(busy == (m_ph != 0), "R3 busy", busy, (m_ph != 0));
      e_snoop = (m_ph == 1) ? ~(N'(1) << m_cur) : '0;
      chk(snoop_valid == e_snoop, "R4 snoop_valid", snoop_valid, e_snoop);
      if (m_ph == 1)
        chk(snoop_inv == m_kind[1], "R4 snoop_inv", snoop_inv, m_kind[1]);
      chk(resp_valid == ((m_ph == 3) ? (N'(1) << m_cur) : '0), "R5 resp_valid", resp_valid,
          (m_ph == 3) ? (1 << m_cur) : 0);
      if (m_ph == 3) begin
        int es;
        es = m_kind[1] ? 3 : (m_keep ? 1 : 2);
        chk(resp_state == 2'(es), "R7 resp_state", resp_state, es);
        chk(resp_data == (m_kind[0] ? m_mem : '0), "R6/R8 resp_data", resp_data,
            m_kind[0] ? m_mem : 0);
        resp_seen++;
      end else begin
        chk(resp_state == 2'd0, "R7 resp_state idle", resp_state, 0);
      end
      // agents react
      for (int i = 0; i < N; i++) begin
        if (req_accept[i]) taken[i] = 1;
        if (snoop_valid[i]) begin
          a_m[i] = (cs[i] == 3);
          a_d[i] = cd[i];
          a_k[i] = !snoop_inv && cs[i] != 0;
          cs[i]  = snoop_inv ? 0 : ((cs[i] != 0) ? 1 : 0);
          ackcnt[i] = 1 + int'(rnd() % 3);
        end
        if (resp_valid[i]) begin
          cs[i] = int'(resp_state);
          if (rkind[i][0]) cd[i] = resp_data;
          if (rkind[i][1]) begin cd[i] = W'(store_val); store_val++; end
          waiting[i] = 0; taken[i] = 0;
        end
      end
      // R10 system invariants
      begin
        int nm, ne, ns;
        nm = 0; ne = 0; ns = 0;
        for (int i = 0; i < N; i++) begin
          if (cs[i] == 3) nm++;
          if (cs[i] == 2) ne++;
          if (cs[i] == 1) ns++;
        end
        chk(nm <= 1, "R10 single Modified", nm, 1);
        chk(!((nm + ne) > 0 && ns > 0) && (nm + ne) <= 1, "R10 owner excludes sharers",
            (nm + ne) * 10 + ns, (nm + ne));
      end
      // advance model to the next edge
      case (m_ph)
        0: if (win >= 0) begin
             m_cur = win; m_ptr = win; m_kind = rkind[win]; m_ph = 1;
           end
        1: begin m_ph = 2; m_left = N - 1; m_keep = 0; end
        2: begin
             for (int i = 0; i < N; i++) begin
               if (ack_valid[i] && i != m_cur) begin
                 m_left--;
                 if (ack_mod[i]) begin m_mem = ack_data[i*W +: W]; wb_resp++; end
                 if (ack_keep[i]) m_keep = 1;
               end
             end
             if (m_left == 0) m_ph = 3;
           end
        default: m_ph = 0;
      endcase
      // watchdog
      busy_run = busy ? busy_run + 1 : 0;
      if (busy_run > 200) begin
        chk(1'b0, "R5 watchdog: transaction never completed", busy_run, 200);
        break;
      end
    end
    chk(resp_seen > 50, "R5 responses observed", resp_seen, 50);
    chk(wb_resp > 0, "R6 write-back exercised", wb_resp, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule